// File: doc/BRIEF.md
# Shaped Dual-Port Memory

This block is a synchronous memory with two fully independent ports, A and B, that share one store of data bits and a smaller store of parity bits. Each port has its own clock, and both ports may read or write in the same cycle. At build time each port picks one of six word shapes. A port's shape sets its word width, its address width and whether it carries parity. The two ports may pick different shapes, so one side can, for example, write single bits while the other reads 36-bit words over the same bits.

Both stores are addressed linearly. A word of width w at address a covers data bits a*w up to a*w+w-1. In the byte-wide and wider shapes, one parity bit goes with each data byte. Reads are registered. The port output shows the addressed word's contents from before any write in the same cycle. A per-port synchronous clear empties that port's output register only.

Top module: `dpram_shaped`

## Requirements
- R1: The shape parameter codes are 0..5, giving 1, 2, 4, 9, 18 and 36-bit words. The address width is log2(NBYTES*8/d), where d is the data width (1, 2, 4, 8, 16 or 32). With NBYTES=2048 this gives 14, 13, 12, 11, 10 and 9 bits. The highest address reaches the last bits of the store.
- R2: The data word at address a of a port with data width d is store bits a*d..a*d+d-1, least significant bit first. A word written through one port reads back through the other port at the matching bit positions, whatever the shapes.
- R3: The 9, 18 and 36-bit shapes split into 8, 16 or 32 data bits plus 1, 2 or 4 parity bits. Parity bit i of the word at address a is parity entry a*(d/8)+i. The 1, 2 and 4-bit shapes have a 1-bit parity port: its input is ignored, writes from those shapes leave the parity store untouched, and their parity output reads 0.
- R4: A read issued with the enable high on clock edge k shows its word on the data and parity outputs right after edge k, and those outputs stay until the port's next enabled edge.
- R5: During a write, the port's output shows the contents of the addressed word from before that write.
- R6: With the enable high and the synchronous clear high, the port's data and parity outputs become 0 at the edge. The store is unchanged, and a write issued in the same cycle still takes place.
- R7: With the enable low, a port does not write, ignores its synchronous clear and holds both outputs.
- R8: The ports run on unrelated clocks. Accesses in overlapping time to different bytes of the store do not disturb each other.
- R9: The active-low asynchronous reset clears both ports' output registers to 0. It does not initialise the store.
- R10: A write from the 1, 2 or 4-bit shapes changes only its own bits. The other bits of the same byte keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous reset of the output registers, active low |
| clk_a_i | input | 1 | Port A clock |
| en_a_i | input | 1 | Port A enable |
| we_a_i | input | 1 | Port A write enable |
| srst_a_i | input | 1 | Port A synchronous output clear |
| addr_a_i | input | AW_A | Port A word address |
| wdata_a_i | input | DW_A | Port A write data |
| wpar_a_i | input | PP_A | Port A write parity (ignored in narrow shapes) |
| rdata_a_o | output | DW_A | Port A registered read data |
| rpar_a_o | output | PP_A | Port A registered read parity |
| clk_b_i | input | 1 | Port B clock |
| en_b_i | input | 1 | Port B enable |
| we_b_i | input | 1 | Port B write enable |
| srst_b_i | input | 1 | Port B synchronous output clear |
| addr_b_i | input | AW_B | Port B word address |
| wdata_b_i | input | DW_B | Port B write data |
| wpar_b_i | input | PP_B | Port B write parity (ignored in narrow shapes) |
| rdata_b_o | output | DW_B | Port B registered read data |
| rpar_b_o | output | PP_B | Port B registered read parity |

## Verification
The bench pairs every narrow shape with a wide one and sweeps every address on both sides, so a wrong bit offset or byte stride shows up as data appearing at the wrong address of the other port. A write-path mask that spills into neighbouring bits would corrupt the words next to each narrow write on the reread. If narrow writes leaked into the parity store, the parity read back through the wide side would change. A design that gave write-first output would show the new word during the write sweep instead of the old one. An output clear that did not wait for the enable, or a clear that also erased the store, is caught by the reads that come right after the clear. A lost update when the two clocks write different bytes together fails the reread that follows the overlapping writes.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

  typedef enum logic [2:0] {
    SHAPE_X1  = 3'd0,
    SHAPE_X2  = 3'd1,
    SHAPE_X4  = 3'd2,
    SHAPE_X9  = 3'd3,
    SHAPE_X18 = 3'd4,
    SHAPE_X36 = 3'd5
  } shape_e;

  // bytes a port can touch in one access (36-bit shape)
  localparam int unsigned WIN_BYTES = 4;

  function automatic int unsigned shape_dw(shape_e s);
    case (s)
      SHAPE_X1:  return 1;
      SHAPE_X2:  return 2;
      SHAPE_X4:  return 4;
      SHAPE_X9:  return 8;
      SHAPE_X18: return 16;
      default:   return 32;
    endcase
  endfunction

  function automatic int unsigned shape_pw(shape_e s);
    return (shape_dw(s) >= 8) ? shape_dw(s) / 8 : 0;
  endfunction

  // parity port width, kept at least 1 bit
  function automatic int unsigned shape_ppw(shape_e s);
    return (shape_pw(s) == 0) ? 1 : shape_pw(s);
  endfunction

  function automatic int unsigned shape_aw(shape_e s, int unsigned nbytes);
    return $clog2((nbytes * 8) / shape_dw(s));
  endfunction

endpackage

// File: rtl/dpram_bank.sv
module dpram_bank #(
  parameter int unsigned NBYTES = 2048,
  parameter int unsigned WIN    = 4,
  localparam int unsigned IW    = $clog2(NBYTES),
  localparam int unsigned LW    = WIN * 8
) (
  input  logic          clk_a_i,
  input  logic [IW-1:0] base_a_i,
  input  logic [LW-1:0] wmask_a_i,
  input  logic [LW-1:0] wbyte_a_i,
  input  logic [WIN-1:0] pmask_a_i,
  input  logic [WIN-1:0] wpar_a_i,
  output logic [LW-1:0] rwin_a_o,
  output logic [WIN-1:0] rpar_a_o,
  input  logic          clk_b_i,
  input  logic [IW-1:0] base_b_i,
  input  logic [LW-1:0] wmask_b_i,
  input  logic [LW-1:0] wbyte_b_i,
  input  logic [WIN-1:0] pmask_b_i,
  input  logic [WIN-1:0] wpar_b_i,
  output logic [LW-1:0] rwin_b_o,
  output logic [WIN-1:0] rpar_b_o
);

  // One copy per writer; per-byte toggle pair marks the newest copy.
  // Equal toggles: copy A is current. Different: copy B is current.
  logic [7:0]        mem_a [NBYTES];
  logic [7:0]        mem_b [NBYTES];
  logic [NBYTES-1:0] par_a, par_b;
  logic [NBYTES-1:0] tog_a, tog_b;

  logic [IW-1:0] idx_a [WIN];
  logic [IW-1:0] idx_b [WIN];

  always_comb begin
    for (int j = 0; j < WIN; j++) begin
      idx_a[j] = base_a_i + IW'(j);
      idx_b[j] = base_b_i + IW'(j);
      rwin_a_o[j*8 +: 8] = (tog_a[idx_a[j]] ^ tog_b[idx_a[j]]) ? mem_b[idx_a[j]] : mem_a[idx_a[j]];
      rpar_a_o[j]        = (tog_a[idx_a[j]] ^ tog_b[idx_a[j]]) ? par_b[idx_a[j]] : par_a[idx_a[j]];
      rwin_b_o[j*8 +: 8] = (tog_a[idx_b[j]] ^ tog_b[idx_b[j]]) ? mem_b[idx_b[j]] : mem_a[idx_b[j]];
      rpar_b_o[j]        = (tog_a[idx_b[j]] ^ tog_b[idx_b[j]]) ? par_b[idx_b[j]] : par_a[idx_b[j]];
    end
  end

  // merge into the current byte so the copy that takes ownership is complete
  always_ff @(posedge clk_a_i) begin
    for (int j = 0; j < WIN; j++) begin
      if ((|wmask_a_i[j*8 +: 8]) || pmask_a_i[j]) begin
        mem_a[idx_a[j]] <= (rwin_a_o[j*8 +: 8] & ~wmask_a_i[j*8 +: 8])
                         | (wbyte_a_i[j*8 +: 8] & wmask_a_i[j*8 +: 8]);
        par_a[idx_a[j]] <= pmask_a_i[j] ? wpar_a_i[j] : rpar_a_o[j];
        tog_a[idx_a[j]] <= tog_b[idx_a[j]];
      end
    end
  end

  always_ff @(posedge clk_b_i) begin
    for (int j = 0; j < WIN; j++) begin
      if ((|wmask_b_i[j*8 +: 8]) || pmask_b_i[j]) begin
        mem_b[idx_b[j]] <= (rwin_b_o[j*8 +: 8] & ~wmask_b_i[j*8 +: 8])
                         | (wbyte_b_i[j*8 +: 8] & wmask_b_i[j*8 +: 8]);
        par_b[idx_b[j]] <= pmask_b_i[j] ? wpar_b_i[j] : rpar_b_o[j];
        tog_b[idx_b[j]] <= ~tog_a[idx_b[j]];
      end
    end
  end

endmodule

// File: rtl/dpram_port.sv
module dpram_port import dpram_pkg::*; #(
  parameter shape_e      SHAPE  = SHAPE_X36,
  parameter int unsigned NBYTES = 2048,
  parameter int unsigned WIN    = 4,
  localparam int unsigned DW    = shape_dw(SHAPE),
  localparam int unsigned PW    = shape_pw(SHAPE),
  localparam int unsigned PPW   = shape_ppw(SHAPE),
  localparam int unsigned AW    = shape_aw(SHAPE, NBYTES),
  localparam int unsigned IW    = $clog2(NBYTES),
  localparam int unsigned LW    = WIN * 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic           we_i,
  input  logic           srst_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic [PPW-1:0] wpar_i,
  output logic [DW-1:0]  rdata_o,
  output logic [PPW-1:0] rpar_o,
  output logic [IW-1:0]  base_o,
  output logic [LW-1:0]  wmask_o,
  output logic [LW-1:0]  wbyte_o,
  output logic [WIN-1:0] pmask_o,
  output logic [WIN-1:0] wpar_o,
  input  logic [LW-1:0]  rwin_i,
  input  logic [WIN-1:0] rpar_i
);

  localparam bit          NARROW = (PW == 0);
  localparam int unsigned KB     = NARROW ? 0 : $clog2(PW);
  localparam int unsigned SUBW   = NARROW ? $clog2(8 / DW) : 1;

  logic           wr;
  logic [DW-1:0]  rd_word;
  logic [PPW-1:0] rd_par;

  assign wr = en_i && we_i;

  if (NARROW) begin : g_narrow
    logic [2:0] off;
    logic [7:0] sh;
    logic       unused_n;
    assign unused_n = ^{wpar_i, rpar_i, rwin_i};
    always_comb begin
      base_o  = IW'(addr_i >> SUBW);
      off     = 3'(addr_i[SUBW-1:0]) * 3'(DW);
      wmask_o = wr ? (LW'({DW{1'b1}}) << off) : '0;
      wbyte_o = LW'(wdata_i) << off;
      pmask_o = '0;
      wpar_o  = '0;
      sh      = rwin_i[7:0] >> off;
      rd_word = sh[DW-1:0];
      rd_par  = '0;
    end
  end else begin : g_wide
    logic unused_w;
    assign unused_w = ^{rwin_i, rpar_i};
    always_comb begin
      base_o  = IW'(addr_i) << KB;
      wmask_o = wr ? LW'({DW{1'b1}}) : '0;
      wbyte_o = LW'(wdata_i);
      pmask_o = wr ? WIN'({PW{1'b1}}) : '0;
      wpar_o  = WIN'(wpar_i);
      rd_word = rwin_i[DW-1:0];
      rd_par  = rpar_i[PW-1:0];
    end

    AST_PAR_FOLLOWS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(en_i && we_i) && en_i && !srst_i && addr_i == $past(addr_i)
      |=> rpar_o == $past(wpar_i, 2)); // R3
  end

  // window is read before the bank's write edge, giving old-data output
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      rpar_o  <= '0;
    end else if (en_i) begin
      if (srst_i) begin
        rdata_o <= '0;
        rpar_o  <= '0;
      end else begin
        rdata_o <= rd_word;
        rpar_o  <= rd_par;
      end
    end
  end

  AST_SRST_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && srst_i |=> rdata_o == '0 && rpar_o == '0); // R6

  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(rdata_o) && $stable(rpar_o)); // R7

  AST_READ_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(en_i && we_i) && en_i && !we_i && !srst_i && addr_i == $past(addr_i)
    |=> rdata_o == $past(wdata_i, 2)); // R4

  AST_OLD_DATA_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(en_i && we_i) && en_i && we_i && !srst_i && addr_i == $past(addr_i)
    |=> rdata_o == $past(wdata_i, 2)); // R5

endmodule

// File: rtl/dpram_shaped.sv
module dpram_shaped import dpram_pkg::*; #(
  parameter shape_e      SHAPE_A = SHAPE_X36,
  parameter shape_e      SHAPE_B = SHAPE_X9,
  parameter int unsigned NBYTES  = 2048,
  localparam int unsigned DW_A   = shape_dw(SHAPE_A),
  localparam int unsigned PP_A   = shape_ppw(SHAPE_A),
  localparam int unsigned AW_A   = shape_aw(SHAPE_A, NBYTES),
  localparam int unsigned DW_B   = shape_dw(SHAPE_B),
  localparam int unsigned PP_B   = shape_ppw(SHAPE_B),
  localparam int unsigned AW_B   = shape_aw(SHAPE_B, NBYTES)
) (
  input  logic            rst_ni,
  input  logic            clk_a_i,
  input  logic            en_a_i,
  input  logic            we_a_i,
  input  logic            srst_a_i,
  input  logic [AW_A-1:0] addr_a_i,
  input  logic [DW_A-1:0] wdata_a_i,
  input  logic [PP_A-1:0] wpar_a_i,
  output logic [DW_A-1:0] rdata_a_o,
  output logic [PP_A-1:0] rpar_a_o,
  input  logic            clk_b_i,
  input  logic            en_b_i,
  input  logic            we_b_i,
  input  logic            srst_b_i,
  input  logic [AW_B-1:0] addr_b_i,
  input  logic [DW_B-1:0] wdata_b_i,
  input  logic [PP_B-1:0] wpar_b_i,
  output logic [DW_B-1:0] rdata_b_o,
  output logic [PP_B-1:0] rpar_b_o
);

  localparam int unsigned WIN = WIN_BYTES;
  localparam int unsigned IW  = $clog2(NBYTES);
  localparam int unsigned LW  = WIN * 8;

  logic [IW-1:0]  base_a, base_b;
  logic [LW-1:0]  wmask_a, wmask_b, wbyte_a, wbyte_b, rwin_a, rwin_b;
  logic [WIN-1:0] pmask_a, pmask_b, wpb_a, wpb_b, rpb_a, rpb_b;

  dpram_port #(.SHAPE(SHAPE_A), .NBYTES(NBYTES), .WIN(WIN)) u_port_a (
    .clk_i   (clk_a_i),
    .rst_ni  (rst_ni),
    .en_i    (en_a_i),
    .we_i    (we_a_i),
    .srst_i  (srst_a_i),
    .addr_i  (addr_a_i),
    .wdata_i (wdata_a_i),
    .wpar_i  (wpar_a_i),
    .rdata_o (rdata_a_o),
    .rpar_o  (rpar_a_o),
    .base_o  (base_a),
    .wmask_o (wmask_a),
    .wbyte_o (wbyte_a),
    .pmask_o (pmask_a),
    .wpar_o  (wpb_a),
    .rwin_i  (rwin_a),
    .rpar_i  (rpb_a)
  );

  dpram_port #(.SHAPE(SHAPE_B), .NBYTES(NBYTES), .WIN(WIN)) u_port_b (
    .clk_i   (clk_b_i),
    .rst_ni  (rst_ni),
    .en_i    (en_b_i),
    .we_i    (we_b_i),
    .srst_i  (srst_b_i),
    .addr_i  (addr_b_i),
    .wdata_i (wdata_b_i),
    .wpar_i  (wpar_b_i),
    .rdata_o (rdata_b_o),
    .rpar_o  (rpar_b_o),
    .base_o  (base_b),
    .wmask_o (wmask_b),
    .wbyte_o (wbyte_b),
    .pmask_o (pmask_b),
    .wpar_o  (wpb_b),
    .rwin_i  (rwin_b),
    .rpar_i  (rpb_b)
  );

  dpram_bank #(.NBYTES(NBYTES), .WIN(WIN)) u_bank (
    .clk_a_i   (clk_a_i),
    .base_a_i  (base_a),
    .wmask_a_i (wmask_a),
    .wbyte_a_i (wbyte_a),
    .pmask_a_i (pmask_a),
    .wpar_a_i  (wpb_a),
    .rwin_a_o  (rwin_a),
    .rpar_a_o  (rpb_a),
    .clk_b_i   (clk_b_i),
    .base_b_i  (base_b),
    .wmask_b_i (wmask_b),
    .wbyte_b_i (wbyte_b),
    .pmask_b_i (pmask_b),
    .wpar_b_i  (wpb_b),
    .rwin_b_o  (rwin_b),
    .rpar_b_o  (rpb_b)
  );

endmodule

// File: tb/dpram_shaped_tb.sv
module dpram_harness import dpram_pkg::*; #(
  parameter shape_e      SA = SHAPE_X1,
  parameter shape_e      SB = SHAPE_X36,
  parameter int unsigned NB = 16
) (
  input  logic clk_a,
  input  logic clk_b,
  input  logic rst_ni,
  output logic done,
  output int   errs,
  output int   chks
);
  localparam int unsigned DWA = shape_dw(SA), PWA = shape_pw(SA), PPA = shape_ppw(SA);
  localparam int unsigned AWA = shape_aw(SA, NB), NWA = NB * 8 / DWA;
  localparam int unsigned DWB = shape_dw(SB), PWB = shape_pw(SB), PPB = shape_ppw(SB);
  localparam int unsigned AWB = shape_aw(SB, NB), NWB = NB * 8 / DWB;

  logic en_a = 0, we_a = 0, srst_a = 0, en_b = 0, we_b = 0, srst_b = 0;
  logic [AWA-1:0] addr_a = '0;
  logic [AWB-1:0] addr_b = '0;
  logic [DWA-1:0] wd_a = '0, rd_a;
  logic [DWB-1:0] wd_b = '0, rd_b;
  logic [PPA-1:0] wp_a = '0, rp_a;
  logic [PPB-1:0] wp_b = '0, rp_b;

  logic [NB*8-1:0] ref_d, ref_v;
  logic [NB-1:0]   ref_p, ref_pv;
  logic [35:0] ea_d, eb_d;
  logic [3:0]  ea_p, eb_p;
  bit          ea_v, eb_v;

  dpram_shaped #(.SHAPE_A(SA), .SHAPE_B(SB), .NBYTES(NB)) u_dut (
    .rst_ni(rst_ni),
    .clk_a_i(clk_a), .en_a_i(en_a), .we_a_i(we_a), .srst_a_i(srst_a),
    .addr_a_i(addr_a), .wdata_a_i(wd_a), .wpar_a_i(wp_a),
    .rdata_a_o(rd_a), .rpar_a_o(rp_a),
    .clk_b_i(clk_b), .en_b_i(en_b), .we_b_i(we_b), .srst_b_i(srst_b),
    .addr_b_i(addr_b), .wdata_b_i(wd_b), .wpar_b_i(wp_b),
    .rdata_b_o(rd_b), .rpar_b_o(rp_b)
  );

  function automatic logic [35:0] pat(int a, int s);
    return 36'(a * 2654435 + s * 40503 + 7) ^ {4'(s), 32'(a * 77)};
  endfunction

  function automatic logic [3:0] pat4(int a, int s);
    return 4'(a * 3 + s * 5 + 1);
  endfunction

  task automatic chk(string tag, logic [35:0] act, logic [35:0] exp);
    chks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %m: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // model: data bit a*dw+i, parity entry a*(dw/8)+i
  task automatic rd_model(int dw, int pw, int a, output logic [35:0] od,
                          output logic [3:0] op, output bit ov);
    od = '0; op = '0; ov = 1;
    for (int i = 0; i < dw; i++) begin
      od[i] = ref_d[a*dw+i];
      if (!ref_v[a*dw+i]) ov = 0;
    end
    for (int i = 0; i < pw; i++) begin
      op[i] = ref_p[a*(dw/8)+i];
      if (!ref_pv[a*(dw/8)+i]) ov = 0;
    end
  endtask

  task automatic wr_model(int dw, int pw, int a, logic [35:0] d, logic [3:0] p);
    for (int i = 0; i < dw; i++) begin
      ref_d[a*dw+i] = d[i];
      ref_v[a*dw+i] = 1'b1;
    end
    for (int i = 0; i < pw; i++) begin
      ref_p[a*(dw/8)+i]  = p[i];
      ref_pv[a*(dw/8)+i] = 1'b1;
    end
  endtask

  // call at a negedge of the port clock; returns at the next negedge
  task automatic op_a(bit en, bit we, bit srst, int a, logic [35:0] d,
                      logic [3:0] p, string tag);
    logic [35:0] od; logic [3:0] op; bit ov;
    en_a = en; we_a = we; srst_a = srst;
    addr_a = AWA'(a); wd_a = DWA'(d); wp_a = PPA'(p);
    if (en) begin
      if (srst) begin ea_d = '0; ea_p = '0; ea_v = 1; end
      else begin rd_model(DWA, PWA, a, od, op, ov); ea_d = od; ea_p = op; ea_v = ov; end
      if (we) wr_model(DWA, PWA, a, d, p);
    end
    @(negedge clk_a);
    if (ea_v) begin
      chk(tag, 36'(rd_a), ea_d);
      chk("R3", 36'(rp_a), 36'(ea_p));
    end
  endtask

  task automatic op_b(bit en, bit we, bit srst, int a, logic [35:0] d,
                      logic [3:0] p, string tag);
    logic [35:0] od; logic [3:0] op; bit ov;
    en_b = en; we_b = we; srst_b = srst;
    addr_b = AWB'(a); wd_b = DWB'(d); wp_b = PPB'(p);
    if (en) begin
      if (srst) begin eb_d = '0; eb_p = '0; eb_v = 1; end
      else begin rd_model(DWB, PWB, a, od, op, ov); eb_d = od; eb_p = op; eb_v = ov; end
      if (we) wr_model(DWB, PWB, a, d, p);
    end
    @(negedge clk_b);
    if (eb_v) begin
      chk(tag, 36'(rd_b), eb_d);
      chk("R3", 36'(rp_b), 36'(eb_p));
    end
  endtask

  task automatic idle_a();
    en_a = 0; we_a = 0; srst_a = 0;
  endtask

  task automatic idle_b();
    en_b = 0; we_b = 0; srst_b = 0;
  endtask

  initial begin
    done = 0; errs = 0; chks = 0;
    ref_d = '0; ref_v = '0; ref_p = '0; ref_pv = '0;
    ea_d = '0; ea_p = '0; ea_v = 1; eb_d = '0; eb_p = '0; eb_v = 1;
    wait (rst_ni === 1'b1);
    @(negedge clk_a);
    chk("R9", 36'(rd_a), '0); chk("R9", 36'(rp_a), '0);
    chk("R9", 36'(rd_b), '0); chk("R9", 36'(rp_b), '0);

    // fill through B, read everything through A
    @(negedge clk_b);
    for (int a = 0; a < NWB; a++) op_b(1, 1, 0, a, pat(a, 1), pat4(a, 1), "R2");
    idle_b();
    @(negedge clk_a);
    for (int a = 0; a < NWA; a++) op_a(1, 0, 0, a, '0, '0, "R2");
    // overwrite through A: output must show the B-written word
    for (int a = 0; a < NWA; a++) op_a(1, 1, 0, a, pat(a, 2), pat4(a, 2), "R5");
    for (int a = 0; a < NWA; a++) op_a(1, 0, 0, a, '0, '0, "R10");
    idle_a();
    @(negedge clk_b);
    for (int a = 0; a < NWB; a++) op_b(1, 0, 0, a, '0, '0, "R2");
    idle_b();

    // top address on A lands in the last word of B
    @(negedge clk_a);
    op_a(1, 1, 0, NWA - 1, pat(5, 3), 4'hA, "R1");
    op_a(1, 1, 0, 0, pat(6, 3), 4'h5, "R1");
    idle_a();
    @(negedge clk_b);
    op_b(1, 0, 0, NWB - 1, '0, '0, "R1");
    op_b(1, 0, 0, 0, '0, '0, "R1");

    // disabled port: no write, clear ignored, output held
    op_b(0, 1, 1, 0, ~pat(9, 9), 4'hF, "R7");
    op_b(0, 0, 0, 1, '0, '0, "R7");
    op_b(1, 0, 0, 0, '0, '0, "R7");
    idle_b();
    @(negedge clk_a);
    op_a(0, 1, 1, 1, ~pat(8, 8), 4'hF, "R7");
    op_a(1, 0, 0, 1, '0, '0, "R7");

    // output clear leaves the store alone
    op_a(1, 0, 1, 2, '0, '0, "R6");
    op_a(1, 0, 0, 2, '0, '0, "R6");
    op_a(1, 1, 1, 3, pat(3, 7), pat4(3, 7), "R6");
    op_a(1, 0, 0, 3, '0, '0, "R6");

    // write then read next cycle
    for (int a = 4; a < 8; a++) begin
      op_a(1, 1, 0, a, pat(a, 4), pat4(a, 4), "R4");
      op_a(1, 0, 0, a, '0, '0, "R4");
    end
    op_a(1, 0, 0, 0, '0, '0, "R4");
    op_a(0, 0, 0, 5, '0, '0, "R4");
    idle_a();
    @(negedge clk_b);
    op_b(1, 1, 1, 1, pat(1, 6), pat4(1, 6), "R6");
    op_b(1, 0, 0, 1, '0, '0, "R6");
    idle_b();

    // overlapping traffic: A in the low half of bytes, B in the high half
    fork
      begin
        @(negedge clk_a);
        for (int a = 0; a < NWA / 2; a++) op_a(1, 1, 0, a, pat(a, 11), pat4(a, 11), "R8");
        idle_a();
      end
      begin
        @(negedge clk_b);
        for (int a = NWB / 2; a < NWB; a++) op_b(1, 1, 0, a, pat(a, 12), pat4(a, 12), "R8");
        idle_b();
      end
    join
    @(negedge clk_a);
    for (int a = 0; a < NWA; a++) op_a(1, 0, 0, a, '0, '0, "R8");
    idle_a();
    @(negedge clk_b);
    for (int a = 0; a < NWB; a++) op_b(1, 0, 0, a, '0, '0, "R8");
    idle_b();
    done = 1;
  end
endmodule

module dpram_shaped_tb;
  import dpram_pkg::*;

  localparam int WATCHDOG = 50000;

  logic clk_a = 0, clk_b = 0, rst_ni = 0;
  logic d0, d1, d2;
  int   e0, e1, e2, c0, c1, c2;
  bit   reported = 0;

  always #10 clk_a = ~clk_a;
  always #13 clk_b = ~clk_b;

  dpram_harness #(.SA(SHAPE_X1), .SB(SHAPE_X36), .NB(16)) h_x1 (
    .clk_a(clk_a), .clk_b(clk_b), .rst_ni(rst_ni), .done(d0), .errs(e0), .chks(c0));
  dpram_harness #(.SA(SHAPE_X2), .SB(SHAPE_X18), .NB(16)) h_x2 (
    .clk_a(clk_a), .clk_b(clk_b), .rst_ni(rst_ni), .done(d1), .errs(e1), .chks(c1));
  dpram_harness #(.SA(SHAPE_X4), .SB(SHAPE_X9), .NB(16)) h_x4 (
    .clk_a(clk_a), .clk_b(clk_b), .rst_ni(rst_ni), .done(d2), .errs(e2), .chks(c2));

  initial begin
    repeat (4) @(posedge clk_a);
    @(negedge clk_a);
    rst_ni = 1;
  end

  initial begin
    #1;
    wait (d0 === 1'b1 && d1 === 1'b1 && d2 === 1'b1);
    if (!reported) begin
      reported = 1;
      $display("Result: errors=%0d of %0d checks", e0 + e1 + e2, c0 + c1 + c2);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk_a);
    if (!reported) begin
      reported = 1;
      $display("FAIL R8 watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", e0 + e1 + e2 + 1, c0 + c1 + c2 + 1);
      $finish;
    end
  end
endmodule